// File: doc/BRIEF.md
# Interrupt Request Latch Unit

This block catches one-cycle request pulses from eighteen interrupt sources and holds them in two 8-bit request-flag registers, one flag per request line. Two of the lines are each fed by a transmit/receive pair (one per serial port), and two neighbouring flags belong to the watchdog and the watch timer. For all six of these sources a separate 6-bit identification register records which one fired, so that a service routine can tell them apart. Software can read and write every flag in all three registers over a simple single-cycle register bus.

Whenever any flag is set, the block raises a pending line towards the CPU. When the CPU reports the end of an instruction while a request is pending, the block runs a fixed acceptance delay of eight clock cycles. It then issues a one-cycle acknowledge and clears the flag that the external selection logic names on a 4-bit index. The identification bits are left alone by acceptance and only software can clear them.

Top module: `irq_latch_unit`

## Requirements
- R1: After synchronous reset, all three registers read 0x00, `irq_pending` is low and `irq_ack` is low.
- R2: A one-cycle pulse on `src_req[i]` sets its flag at the next clock edge. `src_req` indices 0..3 are external inputs 0..3 and map to bits 7..4 of the high register (address 0). Index 8 (serial I/O) maps to high bit 1 and index 9 (timer 0) to high bit 0. Indices 10..13 are timers 1..4 and map to low-register (address 1) bits 7..4. Index 14 (A/D) maps to low bit 3, index 15 (watchdog) to low bit 2, index 16 (watch timer) to low bit 1 and index 17 (basic interval timer) to low bit 0.
- R3: Paired sources share a flag and also mark their identity. Index 4 (serial port 0 transmit) and index 5 (serial port 0 receive) both set high bit 3. Index 6 (serial port 1 transmit) and index 7 (serial port 1 receive) both set high bit 2. The identification register (address 2) gets bit 5 for index 5, bit 4 for index 4, bit 3 for index 7, bit 2 for index 6, bit 1 for index 16 and bit 0 for index 15.
- R4: An identification bit stays set through acceptance and can be cleared only by a register write.
- R5: A request flag stays set until its source is accepted, software writes it to 0, or reset occurs.
- R6: A write with `bus_wr_en` high loads `bus_wdata` into the register at `bus_addr`: 0 is high, 1 is low, 2 is identification. `bus_rdata` shows that register in the same cycle. Identification bits 7:6 always read 0, and address 3 reads 0 and ignores writes.
- R7: If a hardware set and a software write of 0 or an acceptance clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_pending` is high exactly when at least one request flag is set.
- R9: If `instr_done` is high in cycle n while `irq_pending` is high and no acceptance is running, `irq_ack` is high for exactly cycle n+8. An `instr_done` that arrives while an acceptance is running, or while nothing is pending, is ignored.
- R10: In the acknowledge cycle, the flag selected by `ack_idx` is cleared: value 15..8 selects high bits 7..0 and 7..0 selects low bits 7..0. No other flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 18 | One-cycle request pulses, one per source |
| bus_addr | input | 2 | Register select |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| instr_done | input | 1 | Current instruction has completed |
| ack_idx | input | 4 | Flag index to clear on acknowledge |
| irq_pending | output | 1 | At least one request flag is set |
| irq_ack | output | 1 | Acceptance complete, one cycle |

## Verification
A hardware request can arrive in the same cycle as a software write of 0 to its register, or in the same cycle as the acknowledge that clears the flag of that source. The bench provokes the first case by writing 0x00 to the high register while pulsing an external source. It provokes the second by watching for the acknowledge and then pulsing the source that `ack_idx` names before the next edge. In both cases it reads the register back and expects the bit to still be set. A second `instr_done` during the wait is also applied, and exactly one acknowledge is expected.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam int REG_W         = 8;
    localparam int NUM_FLAGS     = 16;
    localparam int NUM_BANKS     = NUM_FLAGS / REG_W;
    localparam int ID_W          = 6;
    localparam int NUM_SRC       = 18;
    localparam int ADDR_W        = 2;
    localparam int IDX_W         = $clog2(NUM_FLAGS);
    localparam int ACCEPT_CYCLES = 8;
    localparam int NUM_EXT       = 4;
    localparam int NUM_TMR       = 5;

    // source positions on the request vector
    localparam int SRC_EXT0  = 0;
    localparam int SRC_U0TX  = 4;
    localparam int SRC_U0RX  = 5;
    localparam int SRC_U1TX  = 6;
    localparam int SRC_U1RX  = 7;
    localparam int SRC_SIO   = 8;
    localparam int SRC_TMR0  = 9;
    localparam int SRC_ADC   = 14;
    localparam int SRC_WDOG  = 15;
    localparam int SRC_WTMR  = 16;
    localparam int SRC_BTMR  = 17;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_HI   = 2'd0,
        ADDR_LO   = 2'd1,
        ADDR_ID   = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             en;
        reg_addr_e        addr;
        logic [REG_W-1:0] data;
    } bus_wr_t;

    // route source pulses onto combined flag positions {high, low}
    function automatic logic [NUM_FLAGS-1:0] src_to_flags(input logic [NUM_SRC-1:0] s);
        logic [NUM_FLAGS-1:0] f;
        f = '0;
        for (int i = 0; i < NUM_EXT; i++) f[NUM_FLAGS-1-i] = s[SRC_EXT0+i];
        f[11] = s[SRC_U0TX] | s[SRC_U0RX];
        f[10] = s[SRC_U1TX] | s[SRC_U1RX];
        f[9]  = s[SRC_SIO];
        for (int i = 0; i < NUM_TMR; i++) f[8-i] = s[SRC_TMR0+i];
        f[3]  = s[SRC_ADC];
        f[2]  = s[SRC_WDOG];
        f[1]  = s[SRC_WTMR];
        f[0]  = s[SRC_BTMR];
        return f;
    endfunction

    function automatic logic [ID_W-1:0] src_to_id(input logic [NUM_SRC-1:0] s);
        return {s[SRC_U0RX], s[SRC_U0TX], s[SRC_U1RX], s[SRC_U1TX], s[SRC_WTMR], s[SRC_WDOG]};
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_latch_pkg::*;
#(
    parameter int FLAGS = NUM_FLAGS,
    parameter int IDB   = ID_W,
    parameter int RW    = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FLAGS-1:0] flag_set,
    input  logic [IDB-1:0]   id_set,
    input  logic [FLAGS-1:0] flag_clr,
    input  bus_wr_t          wr,
    output logic [FLAGS-1:0] flags,
    output logic [IDB-1:0]   id_bits
);

    localparam int BANKS = FLAGS / RW;

    logic [FLAGS-1:0] wr_mask;
    logic [FLAGS-1:0] wr_val;
    logic             id_wr;

    // bank g holds flag bits g*RW.. ; the top bank sits at address 0
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic hit;
        assign hit = wr.en && (wr.addr == reg_addr_e'(BANKS - 1 - g));
        assign wr_mask[g*RW +: RW] = {RW{hit}};
        assign wr_val[g*RW +: RW]  = wr.data;
    end

    assign id_wr = wr.en && (wr.addr == ADDR_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            id_bits <= '0;
        end else begin
            flags   <= ((flags & ~flag_clr) & ~wr_mask) | (wr_val & wr_mask) | flag_set;
            id_bits <= (id_wr ? wr.data[IDB-1:0] : id_bits) | id_set;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (flags == '0) && (id_bits == '0)); // R1

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R7

    AST_ID_STICKY: assert property (@(posedge clk) disable iff (rst)
        !id_wr |=> ((id_bits & $past(id_bits)) == $past(id_bits))); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((flag_clr != '0) && (wr_mask == '0) && (flag_set == '0))
        |=> ((flags & $past(flag_clr)) == '0)); // R10

    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        ((flag_clr == '0) && (wr_mask == '0)) |=> ((flags & $past(flags)) == $past(flags))); // R5

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_latch_pkg::*;
#(
    parameter int DELAY = ACCEPT_CYCLES,
    parameter int FLAGS = NUM_FLAGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pending,
    input  logic                     instr_done,
    input  logic [$clog2(FLAGS)-1:0] ack_idx,
    output logic                     irq_ack,
    output logic [FLAGS-1:0]         flag_clr
);

    localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;

    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (instr_done && pending) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(DELAY - 1);
        end
    end

    assign irq_ack  = busy && (cnt == '0);
    assign flag_clr = irq_ack ? (FLAGS'(1) << ack_idx) : '0;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack); // R9

    AST_START_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(instr_done) && $past(pending))); // R9

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !irq_ack) |=> busy); // R9

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_clr) && (irq_ack == (flag_clr != '0))); // R10

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_latch_pkg::*;
#(
    parameter int FLAGS = NUM_FLAGS,
    parameter int IDB   = ID_W,
    parameter int RW    = REG_W
) (
    input  reg_addr_e        addr,
    input  logic [FLAGS-1:0] flags,
    input  logic [IDB-1:0]   id_bits,
    output logic [RW-1:0]    rdata
);

    always_comb begin
        unique case (addr)
            ADDR_HI: rdata = flags[FLAGS-1 -: RW];
            ADDR_LO: rdata = flags[RW-1:0];
            ADDR_ID: rdata = {{(RW-IDB){1'b0}}, id_bits};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_latch_unit.sv
module irq_latch_unit
    import irq_latch_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               instr_done,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic               irq_pending,
    output logic               irq_ack
);

    bus_wr_t              wr;
    logic [NUM_FLAGS-1:0] flags;
    logic [ID_W-1:0]      id_bits;
    logic [NUM_FLAGS-1:0] flag_clr;

    assign wr.en   = bus_wr_en;
    assign wr.addr = reg_addr_e'(bus_addr);
    assign wr.data = bus_wdata;

    irq_flag_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .flag_set (src_to_flags(src_req)),
        .id_set   (src_to_id(src_req)),
        .flag_clr (flag_clr),
        .wr       (wr),
        .flags    (flags),
        .id_bits  (id_bits)
    );

    assign irq_pending = |flags;

    irq_accept_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .pending    (irq_pending),
        .instr_done (instr_done),
        .ack_idx    (ack_idx),
        .irq_ack    (irq_ack),
        .flag_clr   (flag_clr)
    );

    irq_read_mux u_rd (
        .addr    (reg_addr_e'(bus_addr)),
        .flags   (flags),
        .id_bits (id_bits),
        .rdata   (bus_rdata)
    );

    AST_PEND_AFTER_SET: assert property (@(posedge clk) disable iff (rst)
        (src_req != '0) |=> irq_pending); // R8

endmodule

// File: tb/irq_latch_unit_bench.sv
`timescale 1ns/1ps
module irq_latch_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [17:0] src_req;
    logic [1:0]  bus_addr;
    logic        bus_wr_en;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        instr_done;
    logic [3:0]  ack_idx;
    logic        irq_pending;
    logic        irq_ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_latch_unit u_irq_latch_unit (
        .clk(clk), .rst(rst), .src_req(src_req),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .instr_done(instr_done), .ack_idx(ack_idx),
        .irq_pending(irq_pending), .irq_ack(irq_ack)
    );

    typedef struct packed {
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
    } vec_t;

    // R6 write/readback table
    localparam vec_t VECS [8] = '{
        '{2'd0, 8'hA5, 8'hA5},
        '{2'd1, 8'h3C, 8'h3C},
        '{2'd2, 8'hFF, 8'h3F},
        '{2'd3, 8'hFF, 8'h00},
        '{2'd0, 8'h00, 8'h00},
        '{2'd1, 8'h00, 8'h00},
        '{2'd2, 8'h2A, 8'h2A},
        '{2'd2, 8'h00, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        tick();
        bus_wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        src_req      = '0;
        src_req[idx] = 1'b1;
        tick();
        src_req      = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int acks;
        rst = 1'b1; src_req = '0; bus_addr = '0; bus_wr_en = 1'b0;
        bus_wdata = '0; instr_done = 1'b0; ack_idx = '0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        read_chk(2'd0, 8'h00, "R1 high reg");
        read_chk(2'd1, 8'h00, "R1 low reg");
        read_chk(2'd2, 8'h00, "R1 id reg");
        check(!irq_pending && !irq_ack, "R1 outputs", {irq_pending, irq_ack}, 0);

        // R6 table walk
        for (int i = 0; i < 8; i++) begin
            reg_write(VECS[i].addr, VECS[i].wdata);
            read_chk(VECS[i].addr, VECS[i].exp, "R6 table");
        end
        check(!irq_pending, "R8 idle", irq_pending, 0);

        // R2 single sources
        pulse(2);
        read_chk(2'd0, 8'h20, "R2 ext2");
        pulse(12);
        read_chk(2'd1, 8'h20, "R2 timer3");
        check(irq_pending, "R8 pending", irq_pending, 1);

        // R3 paired sources
        pulse(4);
        pulse(7);
        pulse(15);
        read_chk(2'd0, 8'h2C, "R3 shared flags");
        read_chk(2'd1, 8'h24, "R3 watchdog flag");
        read_chk(2'd2, 8'h19, "R3 id bits");

        // R7 set beats write of zero
        src_req[0] = 1'b1;
        reg_write(2'd0, 8'h00);
        src_req = '0;
        read_chk(2'd0, 8'h80, "R7 write vs set");

        // R5 hold
        repeat (5) tick();
        read_chk(2'd0, 8'h80, "R5 hold");

        // R9/R10 acceptance of ext0 (index 15)
        ack_idx = 4'd15;
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        acks = 0;
        for (int k = 1; k < 8; k++) begin
            if (irq_ack) acks++;
            tick();
        end
        check(acks == 0, "R9 early ack", acks, 0);
        check(irq_ack, "R9 ack at n+8", irq_ack, 1);
        tick();
        check(!irq_ack, "R9 ack width", irq_ack, 0);
        read_chk(2'd0, 8'h00, "R10 cleared");
        read_chk(2'd1, 8'h24, "R10 others kept");
        read_chk(2'd2, 8'h19, "R4 id kept");

        // R9 second strobe while busy ignored; accept timer3 (index 5)
        ack_idx = 4'd5;
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        acks = 0;
        for (int k = 0; k < 20; k++) begin
            if (k == 3) instr_done = 1'b1;
            if (irq_ack) acks++;
            tick();
            instr_done = 1'b0;
        end
        check(acks == 1, "R9 busy strobe", acks, 1);
        read_chk(2'd1, 8'h04, "R10 timer3 cleared");

        // R7 set beats acceptance clear (watchdog, index 2)
        ack_idx = 4'd2;
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (irq_ack) begin
                src_req[15] = 1'b1;
                tick();
                src_req = '0;
                break;
            end
            tick();
        end
        read_chk(2'd1, 8'h04, "R7 ack vs set");
        repeat (10) tick();

        // R4 software clear of id; R9 no pending no ack
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h00);
        read_chk(2'd2, 8'h00, "R4 id write clear");
        check(!irq_pending, "R8 cleared", irq_pending, 0);
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        acks = 0;
        for (int k = 0; k < 12; k++) begin
            if (irq_ack) acks++;
            tick();
        end
        check(acks == 0, "R9 idle strobe", acks, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule